// File: doc/BRIEF.md
# Occupancy-Driven Queue Resizing Controller

This controller decides how much of one partitioned buffer, such as an issue queue, a reorder buffer or a load/store queue, is switched on. The buffer is split into equal partitions. Every cycle the controller receives the number of occupied entries and the number of instructions that could not dispatch. It drives a partition-enable mask and the resulting active entry count.

Shrinking is slow and careful. At the end of each fixed-length sample period the controller takes one occupancy sample. After a set number of samples it averages them with a shift. It removes partitions only when the active size is more than one partition above that average. A mode input picks the shrink amount: one partition per decision, or as many whole partitions as fit in the surplus. Growing is fast. Dispatch-blocked counts are summed inside the current period, and one partition comes back the moment that sum passes a threshold. Instruction throughput plays no part in either decision. Partitions are added and removed at the high end of the mask, and the lowest partition always stays on.

Top module: `resize_ctrl`

## Requirements
- R1: Reset enables every partition, so part_en is all ones and active_size equals NUM_PARTS*PART_ENTRIES.
- R2: Occupancy is sampled on the last cycle of every SAMPLE_PERIOD-cycle period, counted from reset release. A shrink decision is taken only at every 2**AVG_LOG2-th sample and uses floor(sum of those samples / 2**AVG_LOG2). Without a decision or an upsize, part_en holds its value.
- R3: A shrink decision removes partitions only when active_size minus the average is strictly greater than PART_ENTRIES. A surplus of exactly PART_ENTRIES or less leaves the size unchanged.
- R4: With aggr_mode=0, a shrink decision removes exactly one partition.
- R5: With aggr_mode=1, a shrink decision removes floor((active_size - average) / PART_ENTRIES) partitions.
- R6: At least one partition, bit 0 of part_en, is always enabled. A larger removal is clamped to leave exactly one.
- R7: The blocked counts of the current period are summed, including the current cycle. When the sum is strictly greater than BLOCK_THRESH, one partition is enabled at that clock edge, unless all are already on.
- R8: The blocked sum restarts from zero after an upsize and at every period boundary.
- R9: part_en is a fill from bit 0: bit i is set exactly when i < number of enabled partitions. active_size equals the number of enabled partitions times PART_ENTRIES.
- R10: When an upsize and a shrink decision fall on the same edge, the upsize wins and no partition is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| occupancy | input | $clog2(NUM_PARTS*PART_ENTRIES+1) | Occupied entries this cycle |
| blocked | input | BLK_W | Instructions blocked at dispatch this cycle |
| aggr_mode | input | 1 | 0: shrink one partition per decision, 1: shrink by whole surplus partitions |
| part_en | output | NUM_PARTS | Partition enable mask, bit i for partition i |
| active_size | output | $clog2(NUM_PARTS*PART_ENTRIES+1) | Currently enabled entries |

## Verification
The assertions assume two things about the inputs. Occupancy never exceeds the total entry count. aggr_mode changes only while no shrink decision is being taken, so the one-partition bound for conservative mode applies to the decision edge. The stimulus resets before each scenario so that the period phase is known. It holds occupancy and mode constant across whole periods, or changes occupancy only on period boundaries. It drives blocked counts only in short bursts whose timing, relative to period ends and averaging ends, is planned in advance. This keeps every expected size a simple function of the requirements.

// File: rtl/rsz_pkg.sv
package rsz_pkg;

    // How far a shrink decision may cut
    typedef enum logic {
        SHRINK_STEP = 1'b0,
        SHRINK_SPAN = 1'b1
    } shrink_mode_e;

    // Events that may move the partition count on one edge
    typedef struct packed {
        logic grow;   // blocked sum passed threshold
        logic eval;   // averaging window closed
    } resize_evt_t;

    // Bits needed to hold values 0..n
    function automatic int unsigned span_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic bit is_pow2(input int unsigned n);
        return (n != 0) && ((n & (n - 1)) == 0);
    endfunction

endpackage

// File: rtl/rsz_sampler.sv
module rsz_sampler
    import rsz_pkg::*;
#(
    parameter int SAMPLE_PERIOD = 256,
    parameter int AVG_LOG2      = 2,
    parameter int OCC_W         = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OCC_W-1:0] occupancy,
    output logic             tick,
    output logic             avg_valid,
    output logic [OCC_W-1:0] avg_value
);
    localparam int TMR_W = (SAMPLE_PERIOD < 2) ? 1 : $clog2(SAMPLE_PERIOD);
    localparam int SMP_W = (AVG_LOG2 < 1) ? 1 : AVG_LOG2;
    localparam int ACC_W = OCC_W + SMP_W;
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(SAMPLE_PERIOD - 1);
    localparam logic [SMP_W-1:0] SMP_LAST = SMP_W'((1 << AVG_LOG2) - 1);

    logic [TMR_W-1:0] timer_q;
    logic [SMP_W-1:0] smp_q;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_sum;
    logic             window_end;

    assign tick       = (timer_q == TMR_LAST);
    assign window_end = (smp_q == SMP_LAST);
    assign acc_sum    = acc_q + ACC_W'(occupancy);
    assign avg_valid  = tick && window_end;
    assign avg_value  = OCC_W'(acc_sum >> AVG_LOG2);

    always_ff @(posedge clk) begin
        if (rst) begin
            timer_q <= '0;
        end else if (tick) begin
            timer_q <= '0;
        end else begin
            timer_q <= timer_q + TMR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q <= '0;
            acc_q <= '0;
        end else if (tick) begin
            smp_q <= window_end ? '0 : smp_q + SMP_W'(1);
            acc_q <= window_end ? '0 : acc_sum;
        end
    end
endmodule

// File: rtl/rsz_stall_mon.sv
module rsz_stall_mon
    import rsz_pkg::*;
#(
    parameter int BLK_W        = 3,
    parameter int SUM_W        = 12,
    parameter int BLOCK_THRESH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [BLK_W-1:0] blocked,
    output logic             grow_req
);
    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] sum_now;

    assign sum_now  = sum_q + SUM_W'(blocked);
    assign grow_req = (sum_now > SUM_W'(BLOCK_THRESH));

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
        end else if (grow_req || tick) begin
            sum_q <= '0;
        end else begin
            sum_q <= sum_now;
        end
    end
endmodule

// File: rtl/rsz_size_ctrl.sv
module rsz_size_ctrl
    import rsz_pkg::*;
#(
    parameter int NUM_PARTS    = 4,
    parameter int PART_ENTRIES = 8,
    parameter int SIZE_W       = 6,
    parameter int CNT_W        = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  resize_evt_t       evt,
    input  logic [SIZE_W-1:0] avg_value,
    input  shrink_mode_e      mode,
    output logic [CNT_W-1:0]  parts_q
);
    localparam logic [SIZE_W-1:0] PART_SZ = SIZE_W'(PART_ENTRIES);
    localparam logic [CNT_W-1:0]  FULL    = CNT_W'(NUM_PARTS);

    logic [SIZE_W-1:0] active;
    logic [SIZE_W-1:0] gap;
    logic [SIZE_W-1:0] drop_span;
    logic [SIZE_W-1:0] drop;
    logic [SIZE_W-1:0] room;
    logic [SIZE_W-1:0] take;
    logic              shrink;
    logic [CNT_W-1:0]  parts_d;

    assign active = SIZE_W'(parts_q) * PART_SZ;
    assign gap    = (active > avg_value) ? (active - avg_value) : '0;

    generate
        if (is_pow2(PART_ENTRIES)) begin : g_shift_div
            localparam int SHIFT = $clog2(PART_ENTRIES);
            assign drop_span = gap >> SHIFT;
        end else begin : g_true_div
            assign drop_span = gap / PART_SZ;
        end
    endgenerate

    assign shrink = evt.eval && (gap > PART_SZ);
    assign drop   = (mode == SHRINK_SPAN) ? drop_span : SIZE_W'(1);
    assign room   = SIZE_W'(parts_q) - SIZE_W'(1);
    assign take   = (drop > room) ? room : drop;

    always_comb begin
        parts_d = parts_q;
        if (evt.grow) begin
            if (parts_q < FULL) begin
                parts_d = parts_q + CNT_W'(1);
            end
        end else if (shrink) begin
            parts_d = parts_q - CNT_W'(take);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            parts_q <= FULL;
        end else begin
            parts_q <= parts_d;
        end
    end
endmodule

// File: rtl/resize_ctrl.sv
module resize_ctrl
    import rsz_pkg::*;
#(
    parameter int NUM_PARTS     = 4,
    parameter int PART_ENTRIES  = 8,
    parameter int SAMPLE_PERIOD = 256,
    parameter int AVG_LOG2      = 2,
    parameter int BLK_W         = 3,
    parameter int BLOCK_THRESH  = 32
) (
    input  logic                                          clk,
    input  logic                                          rst,
    input  logic [$clog2(NUM_PARTS*PART_ENTRIES+1)-1:0]   occupancy,
    input  logic [BLK_W-1:0]                              blocked,
    input  logic                                          aggr_mode,
    output logic [NUM_PARTS-1:0]                          part_en,
    output logic [$clog2(NUM_PARTS*PART_ENTRIES+1)-1:0]   active_size
);
    localparam int TOTAL  = NUM_PARTS * PART_ENTRIES;
    localparam int SIZE_W = $clog2(TOTAL + 1);
    localparam int CNT_W  = span_bits(NUM_PARTS);
    localparam int SUM_W  = $clog2(SAMPLE_PERIOD + 1) + BLK_W + 1;

    logic              tick;
    logic              avg_valid;
    logic [SIZE_W-1:0] avg_value;
    logic              grow_req;
    logic [CNT_W-1:0]  parts_q;
    resize_evt_t       evt;
    shrink_mode_e      mode;

    assign mode     = shrink_mode_e'(aggr_mode);
    assign evt.grow = grow_req;
    assign evt.eval = avg_valid;

    rsz_sampler #(
        .SAMPLE_PERIOD(SAMPLE_PERIOD),
        .AVG_LOG2     (AVG_LOG2),
        .OCC_W        (SIZE_W)
    ) u_sampler (
        .clk      (clk),
        .rst      (rst),
        .occupancy(occupancy),
        .tick     (tick),
        .avg_valid(avg_valid),
        .avg_value(avg_value)
    );

    rsz_stall_mon #(
        .BLK_W       (BLK_W),
        .SUM_W       (SUM_W),
        .BLOCK_THRESH(BLOCK_THRESH)
    ) u_stall (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .blocked (blocked),
        .grow_req(grow_req)
    );

    rsz_size_ctrl #(
        .NUM_PARTS   (NUM_PARTS),
        .PART_ENTRIES(PART_ENTRIES),
        .SIZE_W      (SIZE_W),
        .CNT_W       (CNT_W)
    ) u_size (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .avg_value(avg_value),
        .mode     (mode),
        .parts_q  (parts_q)
    );

    // Fill from the low end: partition i is on while i is below the count
    generate
        for (genvar gi = 0; gi < NUM_PARTS; gi++) begin : g_mask
            assign part_en[gi] = (parts_q > CNT_W'(gi));
        end
    endgenerate

    assign active_size = SIZE_W'(parts_q) * SIZE_W'(PART_ENTRIES);
endmodule

// File: rtl/rsz_checker.sv
module rsz_checker #(
    parameter int NUM_PARTS    = 4,
    parameter int PART_ENTRIES = 8,
    parameter int SIZE_W       = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_PARTS-1:0] part_en,
    input logic [SIZE_W-1:0]    active_size,
    input logic                 grow_req,
    input logic                 avg_valid,
    input logic [SIZE_W-1:0]    avg_value,
    input logic                 aggr_mode
);
    localparam logic [NUM_PARTS-1:0] ALL_ON = {NUM_PARTS{1'b1}};

    assert_reset_full_R1: assert property (@(posedge clk)
        rst |=> (part_en == ALL_ON) && (int'(active_size) == NUM_PARTS * PART_ENTRIES));

    assert_hold_between_events_R2: assert property (@(posedge clk) disable iff (rst)
        (!grow_req && !avg_valid) |=> $stable(part_en));

    assert_hysteresis_R3: assert property (@(posedge clk) disable iff (rst)
        (avg_valid && !grow_req && (int'(active_size) <= int'(avg_value) + PART_ENTRIES))
        |=> $stable(part_en));

    assert_step_shrink_R4: assert property (@(posedge clk) disable iff (rst)
        (avg_valid && !grow_req && !aggr_mode)
        |=> ($countones(part_en) + 1 >= $countones($past(part_en))));

    assert_keep_one_R6: assert property (@(posedge clk) disable iff (rst)
        part_en[0]);

    assert_grow_one_R7: assert property (@(posedge clk) disable iff (rst)
        (grow_req && (part_en != ALL_ON))
        |=> ($countones(part_en) == $countones($past(part_en)) + 1));

    assert_fill_mask_R9: assert property (@(posedge clk) disable iff (rst)
        ((part_en & (part_en + NUM_PARTS'(1))) == '0)
        && ($countones(part_en) * PART_ENTRIES == int'(active_size)));

    assert_grow_wins_R10: assert property (@(posedge clk) disable iff (rst)
        grow_req |=> ($countones(part_en) >= $countones($past(part_en))));
endmodule

bind resize_ctrl rsz_checker #(
    .NUM_PARTS   (NUM_PARTS),
    .PART_ENTRIES(PART_ENTRIES),
    .SIZE_W      (SIZE_W)
) u_rsz_checker (
    .clk        (clk),
    .rst        (rst),
    .part_en    (part_en),
    .active_size(active_size),
    .grow_req   (grow_req),
    .avg_valid  (avg_valid),
    .avg_value  (avg_value),
    .aggr_mode  (aggr_mode)
);

// File: tb/resize_ctrl_bench.sv
`timescale 1ns/1ps
module resize_ctrl_bench;
    localparam int NP  = 4;
    localparam int PE  = 8;
    localparam int PER = 16;
    localparam int THR = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] occupancy = '0;
    logic [2:0] blocked = '0;
    logic       aggr_mode = 1'b0;
    logic [3:0] part_en;
    logic [5:0] active_size;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct {
        string      req;
        logic [3:0] mask;
        int         size;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    resize_ctrl #(
        .NUM_PARTS    (NP),
        .PART_ENTRIES (PE),
        .SAMPLE_PERIOD(PER),
        .AVG_LOG2     (2),
        .BLK_W        (3),
        .BLOCK_THRESH (THR)
    ) u_resize_ctrl (
        .clk        (clk),
        .rst        (rst),
        .occupancy  (occupancy),
        .blocked    (blocked),
        .aggr_mode  (aggr_mode),
        .part_en    (part_en),
        .active_size(active_size)
    );

    // Monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (part_en !== e.mask || int'(active_size) != e.size) begin
                n_fail++;
                $display("FAIL %s: part_en=%b active_size=%0d expected part_en=%b active_size=%0d",
                         e.req, part_en, active_size, e.mask, e.size);
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_parts(input string req, input int parts);
        exp_t e;
        e.req  = req;
        e.mask = 4'((1 << parts) - 1);
        e.size = parts * PE;
        sb_q.push_back(e);
    endtask

    task automatic restart(input logic mode, input logic [5:0] occ);
        rst       = 1'b1;
        blocked   = '0;
        aggr_mode = mode;
        occupancy = occ;
        cycles(3);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            summary();
        end
    end

    initial begin
        // R1 reset state
        restart(1'b0, 6'd30);
        expect_parts("R1", 4);

        // R3: surplus 2 is inside the hysteresis band
        cycles(4 * PER);
        expect_parts("R3", 4);

        // R2, R4: surplus 9, one step taken only at the window end
        restart(1'b0, 6'd23);
        cycles(4 * PER - 1);
        expect_parts("R2", 4);
        cycles(1);
        expect_parts("R4", 3);

        // R3 boundary: surplus exactly one partition keeps size
        restart(1'b0, 6'd24);
        cycles(4 * PER);
        expect_parts("R3", 4);

        // R5, R6: aggressive, surplus 32 clamps to one partition
        restart(1'b1, 6'd0);
        cycles(4 * PER);
        expect_parts("R6", 1);

        // R5: aggressive, surplus 17 removes two partitions
        restart(1'b1, 6'd15);
        cycles(4 * PER);
        expect_parts("R5", 2);

        // R4, R6: conservative stepping down over several windows
        restart(1'b0, 6'd0);
        cycles(4 * PER);
        expect_parts("R4", 3);
        cycles(4 * PER);
        expect_parts("R4", 2);
        cycles(4 * PER);
        expect_parts("R4", 1);
        cycles(4 * PER);
        expect_parts("R6", 1);

        // R2: samples 30,30,2,2 average to 16, surplus 16 drops two
        restart(1'b1, 6'd30);
        cycles(2 * PER);
        occupancy = 6'd2;
        cycles(2 * PER);
        expect_parts("R2", 2);

        // R7, R8, R10: growth driven by blocked counts
        restart(1'b1, 6'd0);
        cycles(4 * PER);
        expect_parts("R6", 1);
        blocked = 3'd3;
        cycles(3);
        expect_parts("R7", 1);
        cycles(1);
        expect_parts("R7", 2);
        cycles(1);
        expect_parts("R8", 2);
        cycles(3);
        expect_parts("R7", 3);
        cycles(4);
        expect_parts("R7", 4);
        cycles(4);
        expect_parts("R9", 4);
        blocked = '0;
        cycles(3 * PER - 2);
        blocked = 3'd7;
        cycles(1);
        expect_parts("R10", 4);
        cycles(1);
        expect_parts("R10", 4);
        blocked = '0;
        cycles(4 * PER);
        expect_parts("R5", 1);

        // R7 exact threshold, R8 period boundary clears the sum
        restart(1'b1, 6'd0);
        cycles(4 * PER);
        cycles(PER - 2);
        blocked = 3'd5;
        cycles(2);
        expect_parts("R7", 1);
        cycles(1);
        expect_parts("R8", 1);
        blocked = '0;

        @(negedge clk);
        #1;
        finished = 1'b1;
        summary();
    end
endmodule